// File: doc/BRIEF.md
# Sleep and Normal Power-Mode Controller

This block decides whether a mixed-signal chip runs or sleeps, and it drives the enable lines that follow from that decision. Three sources can put the chip to sleep. The first is a one-cycle strobe raised when software writes the dedicated sleep address. The second is a level from a configuration bit that stays set until software clears it. The third is a request level that comes in on a general-purpose pin, passes through a synchronizer and takes precedence over the other two. Wake-up events end a sleep that a write started, but only while neither the pin nor the configuration bit is holding the chip asleep.

Out of reset the controller keeps every clock and analog enable off until two things have happened: the supply supervisor has released, and a timeout of `TMO_CYCLES` clocks has run out after that release. If the supervisor asserts again at any point, the count starts over and all outputs go back to their reset values. Every output comes straight from a flop, so each one changes cleanly on a single clock edge.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `sleep_o`, `clk_fast_en_o`, `clk_slow_en_o`, `wake_en_o` and every bit of `blk_en_o` are 0, and `supv_en_o` is 1.
- R2: After `supv_low_i` falls and stays low, `clk_fast_en_o` rises exactly `SYNC_STAGES+TMO_CYCLES+1` rising clock edges later and not before.
- R3: A high on `supv_low_i`, even one cycle long, restarts the timeout. When it arrives while running or sleeping, all outputs return to their R1 values `SYNC_STAGES+2` edges later, and a sleep that a write started is dropped.
- R4: A high on `sleep_addr_wr_i` while running sets `sleep_o` to 1 at the next edge. A write and a wake event in the same cycle also give sleep.
- R5: While `shdn_cfg_i` is 1 the block sleeps, starting at the next edge. It runs again one edge after the bit clears, provided no other source holds sleep.
- R6: `sleep_o` becomes 1 `SYNC_STAGES+1` edges after `pin_sleep_i` rises. While the synchronized pin request is 1, writes and wake events change nothing, and a write seen then does not latch.
- R7: Releasing `pin_sleep_i` returns the block to run exactly `SYNC_STAGES+1` edges later, but only when `shdn_cfg_i` is 0. Otherwise it keeps sleeping.
- R8: A wake event ends a write-started sleep at the next edge. While `shdn_cfg_i` holds sleep, a wake event has no effect.
- R9: A sleep started by a write is not ended when a pin request rises and then falls. It still needs a wake event.
- R10: While sleeping, `blk_en_o` is all 0 and `clk_fast_en_o` is 0. The outputs `clk_slow_en_o`, `supv_en_o` and `wake_en_o` follow `slow_osc_cfg_i`, `supv_cfg_i` and `wake_cfg_i`, with one edge of delay.
- R11: While running, `blk_en_o` equals `blk_req_i` one edge later, both clock enables are 1, `supv_en_o` is 1 and `wake_en_o` equals `wake_cfg_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supv_low_i | input | 1 | Supply supervisor output, high while the supply is low (asynchronous) |
| pin_sleep_i | input | 1 | Sleep request from the pin function, active high (asynchronous) |
| sleep_addr_wr_i | input | 1 | One-cycle strobe for a write to the sleep address |
| shdn_cfg_i | input | 1 | Persistent shutdown configuration bit |
| wake_evt_i | input | 1 | Wake-up event strobe |
| blk_req_i | input | NBLK | Per-block analog enable requests from the control registers |
| wake_cfg_i | input | 1 | Wake-up logic enabled |
| supv_cfg_i | input | 1 | Keep the supervisor powered during sleep |
| slow_osc_cfg_i | input | 1 | Keep the low-speed oscillator running during sleep |
| sleep_o | output | 1 | Sleep indication |
| clk_fast_en_o | output | 1 | Enable for the main clock output |
| clk_slow_en_o | output | 1 | Enable for the low-speed clock output |
| blk_en_o | output | NBLK | Analog block enables |
| wake_en_o | output | 1 | Wake-up logic power enable |
| supv_en_o | output | 1 | Supervisor power enable |

## Verification
Some properties can be checked on every cycle without knowing the scenario: a supervisor assertion clears the timeout, a held sleep source forces sleep on the next edge, a pin request overrides writes and wakes, a wake event clears a write-started sleep, and clocks and analog enables stay off while sleeping or before the timeout has ended. Other behaviour needs the bench's scenarios. These include the exact latency from supervisor release, the restart after a one-cycle glitch, the rule that a pin release exits only when the pin caused the sleep, the way a write-started sleep survives a pin pulse, and the outputs in sleep following the configuration inputs.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
   typedef enum logic [1:0] {
      MD_OFF   = 2'd0,
      MD_RUN   = 2'd1,
      MD_SLEEP = 2'd2
   } pm_mode_e;

   localparam int SYNC_BITS = 2;
   localparam int SYNC_PIN  = 0;
   localparam int SYNC_SUPV = 1;
endpackage

// File: rtl/pwrmode_sync.sv
module pwrmode_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("pwrmode_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/pwrmode_por.sv
module pwrmode_por #(
   parameter int TMO_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supv_s,
   output logic ready_q
);
   localparam int CW = $clog2(TMO_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

   if (TMO_CYCLES < 1) begin : g_bad_tmo
      $error("pwrmode_por: TMO_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (supv_s) begin
         cnt_q   <= '0;
         ready_q <= 1'b0;
      end else if (!ready_q) begin
         if (cnt_q == LAST) ready_q <= 1'b1;
         else               cnt_q   <= cnt_q + 1'b1;
      end
   end

   assert_supv_restart_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      supv_s |=> (!ready_q && cnt_q == '0));

   assert_tmo_elapsed_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> ($past(cnt_q) == LAST && !$past(supv_s)));
endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
   import pwrmode_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ready,
   input  logic     pin_s,
   input  logic     shdn,
   input  logic     wr,
   input  logic     wake,
   output pm_mode_e mode_d
);
   logic     hold;
   logic     swh_q, swh_d;
   pm_mode_e mode_q;

   assign hold = pin_s | shdn;

   always_comb begin
      if (!ready)    swh_d = 1'b0;
      else if (hold) swh_d = swh_q;
      else if (wr)   swh_d = 1'b1;
      else if (wake) swh_d = 1'b0;
      else           swh_d = swh_q;
   end

   always_comb begin
      if (!ready)              mode_d = MD_OFF;
      else if (hold || swh_d)  mode_d = MD_SLEEP;
      else                     mode_d = MD_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swh_q  <= 1'b0;
         mode_q <= MD_OFF;
      end else begin
         swh_q  <= swh_d;
         mode_q <= mode_d;
      end
   end

   assert_wake_clears_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ready && swh_q && !hold && wake && !wr) |=> (mode_q == MD_RUN));

   assert_pin_precedence_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ready && pin_s) |=> (mode_q == MD_SLEEP && $stable(swh_q)));

   assert_write_sleeps_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ready && wr) |=> (mode_q == MD_SLEEP));
endmodule

// File: rtl/pwrmode_en.sv
module pwrmode_en
   import pwrmode_pkg::*;
#(
   parameter int NBLK = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  pm_mode_e        mode_d,
   input  logic [NBLK-1:0] blk_req,
   input  logic            wake_cfg,
   input  logic            supv_cfg,
   input  logic            slow_cfg,
   output logic            sleep_q,
   output logic            fast_q,
   output logic            slow_q,
   output logic [NBLK-1:0] blk_q,
   output logic            wake_q,
   output logic            supv_q
);
   if (NBLK < 1) begin : g_bad_nblk
      $error("pwrmode_en: NBLK must be at least 1");
   end

   logic run, slp;
   assign run = (mode_d == MD_RUN);
   assign slp = (mode_d == MD_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q <= 1'b0;
         fast_q  <= 1'b0;
         slow_q  <= 1'b0;
         wake_q  <= 1'b0;
         supv_q  <= 1'b1;
      end else begin
         sleep_q <= slp;
         fast_q  <= run;
         slow_q  <= run | (slp & slow_cfg);
         wake_q  <= (run | slp) & wake_cfg;
         supv_q  <= !slp | supv_cfg;
      end
   end

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) blk_q[b] <= 1'b0;
         else        blk_q[b] <= run & blk_req[b];
      end
   end

   assert_sleep_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      sleep_q |-> (blk_q == '0 && !fast_q));
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
   import pwrmode_pkg::*;
#(
   parameter int NBLK        = 6,
   parameter int TMO_CYCLES  = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            supv_low_i,
   input  logic            pin_sleep_i,
   input  logic            sleep_addr_wr_i,
   input  logic            shdn_cfg_i,
   input  logic            wake_evt_i,
   input  logic [NBLK-1:0] blk_req_i,
   input  logic            wake_cfg_i,
   input  logic            supv_cfg_i,
   input  logic            slow_osc_cfg_i,
   output logic            sleep_o,
   output logic            clk_fast_en_o,
   output logic            clk_slow_en_o,
   output logic [NBLK-1:0] blk_en_o,
   output logic            wake_en_o,
   output logic            supv_en_o
);
   localparam logic [SYNC_BITS-1:0] SYNC_RST = SYNC_BITS'(1) << SYNC_SUPV;

   logic [SYNC_BITS-1:0] raw, synced;
   logic                 pin_s, supv_s, ready;
   pm_mode_e             mode_d;

   assign raw[SYNC_PIN]  = pin_sleep_i;
   assign raw[SYNC_SUPV] = supv_low_i;
   assign pin_s  = synced[SYNC_PIN];
   assign supv_s = synced[SYNC_SUPV];

   pwrmode_sync #(.W(SYNC_BITS), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

   pwrmode_por #(.TMO_CYCLES(TMO_CYCLES)) u_por (
      .clk(clk), .rst_n(rst_n), .supv_s(supv_s), .ready_q(ready));

   pwrmode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ready(ready), .pin_s(pin_s),
      .shdn(shdn_cfg_i), .wr(sleep_addr_wr_i), .wake(wake_evt_i), .mode_d(mode_d));

   pwrmode_en #(.NBLK(NBLK)) u_en (
      .clk(clk), .rst_n(rst_n), .mode_d(mode_d), .blk_req(blk_req_i),
      .wake_cfg(wake_cfg_i), .supv_cfg(supv_cfg_i), .slow_cfg(slow_osc_cfg_i),
      .sleep_q(sleep_o), .fast_q(clk_fast_en_o), .slow_q(clk_slow_en_o),
      .blk_q(blk_en_o), .wake_q(wake_en_o), .supv_q(supv_en_o));

   assert_hold_forces_sleep_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ready && (pin_s || shdn_cfg_i)) |=> sleep_o);

   assert_clk_after_ready_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      clk_fast_en_o |-> $past(ready));
endmodule

// File: tb/pwrmode_ctrl_test.sv
module pwrmode_ctrl_test;
   localparam int NB  = 6;
   localparam int TMO = 8;
   localparam int S   = 2;
   localparam int LAT = S + TMO + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supv_low = 1'b1, pin = 1'b0, wr = 1'b0, shdn = 1'b0, wake = 1'b0;
   logic [NB-1:0] blk_req = 6'b101101;
   logic wake_cfg = 1'b1, supv_cfg = 1'b0, slow_cfg = 1'b1;
   logic sleep_o, fast_o, slow_o, wake_o, supv_o;
   logic [NB-1:0] blk_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwrmode_ctrl #(.NBLK(NB), .TMO_CYCLES(TMO), .SYNC_STAGES(S)) uut (
      .clk(clk), .rst_n(rst_n), .supv_low_i(supv_low), .pin_sleep_i(pin),
      .sleep_addr_wr_i(wr), .shdn_cfg_i(shdn), .wake_evt_i(wake),
      .blk_req_i(blk_req), .wake_cfg_i(wake_cfg), .supv_cfg_i(supv_cfg),
      .slow_osc_cfg_i(slow_cfg), .sleep_o(sleep_o), .clk_fast_en_o(fast_o),
      .clk_slow_en_o(slow_o), .blk_en_o(blk_o), .wake_en_o(wake_o),
      .supv_en_o(supv_o));

   typedef struct {
      string         tag;
      logic [4:0]    flags;
      logic [NB-1:0] blk;
   } exp_t;

   exp_t sb[$];

   // mode: 0 off, 1 run, 2 sleep; flags = {sleep, fast, slow, wake_en, supv_en}
   task automatic expect_mode(input string tag, input int md);
      exp_t e;
      e.tag = tag;
      e.flags = {md == 2, md == 1, (md == 1) || (md == 2 && slow_cfg),
                 (md != 0) && wake_cfg, (md != 2) || supv_cfg};
      e.blk = (md == 1) ? blk_req : '0;
      sb.push_back(e);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_wr();
      wr = 1'b1; tick(1); wr = 1'b0;
   endtask

   task automatic pulse_wake();
      wake = 1'b1; tick(1); wake = 1'b0;
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            exp_t e;
            logic [4:0] act;
            e = sb.pop_front();
            act = {sleep_o, fast_o, slow_o, wake_o, supv_o};
            checks++;
            if (act !== e.flags || blk_o !== e.blk) begin
               failures++;
               $display("FAIL %s: flags=%b blk=%b expected flags=%b blk=%b",
                        e.tag, act, blk_o, e.flags, e.blk);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : driver
      tick(2);
      rst_n = 1'b1;
      tick(1);
      expect_mode("R1 reset values", 0);

      supv_low = 1'b0; tick(5);
      supv_low = 1'b1; tick(1);
      supv_low = 1'b0;
      tick(LAT - 1); expect_mode("R3 glitch restarts timeout", 0);
      tick(1);       expect_mode("R2 clocks after timeout", 1);

      blk_req = 6'b010011; tick(1);
      expect_mode("R11 block enables follow requests", 1);

      pulse_wr(); expect_mode("R4 write enters sleep", 2);
      slow_cfg = 1'b0; supv_cfg = 1'b1; wake_cfg = 1'b0; tick(1);
      expect_mode("R10 sleep outputs follow config", 2);
      slow_cfg = 1'b1; supv_cfg = 1'b0; wake_cfg = 1'b1; tick(1);
      expect_mode("R10 sleep outputs follow config again", 2);
      pulse_wake(); expect_mode("R8 wake ends write sleep", 1);

      wr = 1'b1; wake = 1'b1; tick(1); wr = 1'b0; wake = 1'b0;
      expect_mode("R4 write beats same-cycle wake", 2);
      pulse_wake(); expect_mode("R8 wake after combined cycle", 1);

      shdn = 1'b1; tick(1); expect_mode("R5 shutdown bit sleeps", 2);
      pulse_wake();         expect_mode("R8 wake ignored under shutdown", 2);
      shdn = 1'b0; tick(1); expect_mode("R5 clear shutdown runs", 1);

      pin = 1'b1; tick(S); expect_mode("R6 pin latency", 1);
      tick(1);             expect_mode("R6 pin enters sleep", 2);
      pulse_wr(); pulse_wake();
      expect_mode("R6 pin overrides write and wake", 2);
      pin = 1'b0; tick(S); expect_mode("R7 release latency", 2);
      tick(1);             expect_mode("R7 pin release exits", 1);

      pin = 1'b1; tick(S + 1);
      shdn = 1'b1; tick(1);
      pin = 1'b0; tick(S + 1);
      expect_mode("R7 shutdown keeps sleep after pin release", 2);
      shdn = 1'b0; tick(1); expect_mode("R7 run after shutdown cleared", 1);

      pulse_wr();
      pin = 1'b1; tick(S + 1);
      pin = 1'b0; tick(S + 1);
      expect_mode("R9 write sleep survives pin pulse", 2);
      pulse_wake(); expect_mode("R9 wake still needed", 1);

      supv_low = 1'b1; tick(S + 1); expect_mode("R3 brownout latency", 1);
      tick(1);                      expect_mode("R3 brownout drops outputs", 0);
      supv_low = 1'b0; tick(LAT);   expect_mode("R2 recovery after brownout", 1);

      pulse_wr(); expect_mode("R4 sleep before brownout", 2);
      supv_low = 1'b1; tick(S + 2); expect_mode("R3 brownout from sleep", 0);
      supv_low = 1'b0; tick(LAT);   expect_mode("R3 write sleep forgotten", 1);

      tick(2);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule